// File: doc/BRIEF.md
# Bus Error Exception Stacking Sequencer

This block is the control sequencer a small 16-bit processor core uses to take a bus error exception. While a bus cycle is in progress it watches the error input. When an error is seen, it captures the status register, the program counter and the fault details. It then waits until the aborted cycle has finished and the error line has been released.

Once the error line is released, it pushes an exception frame onto the supervisor stack one 16-bit word at a time through a memory port with a request/acknowledge handshake. It then fetches the handler address from the vector table with two word reads, loads that address as the new program counter, and signals completion with a one-clock pulse.

A mode input selects between two frame formats. The short frame carries four words of fault detail. The long frame carries a format/vector-offset word followed by a block of internal state words, which the core supplies through an indexed read port. A further bus error while the frame is being written or the vector is being read stops the sequencer in a halted state, and only reset clears it.

Top module: `buserr_seq`

## Requirements
- R1: An error is taken only in a cycle where `bus_active_i` and `berr_i` are both 1. An error with no active bus cycle is ignored. After an error is taken, no memory request is made until a cycle has passed in which `bus_active_i` and `berr_i` are both 0.
- R2: From the cycle after an error is taken, `sr_o` equals the captured status register with bit 13 (supervisor) set and bit 15 (trace) cleared. This holds throughout stacking.
- R3: Each frame word is written to the stack pointer minus 2, and the pointer is decremented as each write is accepted. The short frame has 7 words and the long frame has `4 + LONG_WORDS` words. `ssp_o` ends at `ssp_i - 2*words`.
- R4: Frame words sit at these byte offsets from the final stack pointer: +0 is the status register, +2 is PC[31:16], +4 is PC[15:0], and the error information starts at +6. Words are pushed from the highest offset down, so the status register is written last.
- R5: In the short frame, offset +6 holds the special status word: bit 4 is the read/write flag, bit 3 is the instruction flag, bits 2:0 are the function code, and the other bits are 0. Offsets +8 and +10 hold the fault address high and low words, and +12 holds the instruction register.
- R6: In the long frame, offset +6 holds `{FMT_CODE, 12'h008}`. Offset +8+2i holds internal state word i, read as `state_word_i` while `state_idx_o` is i, for i from 0 to `LONG_WORDS-1`.
- R7: The stacked status register, program counter and error words are the input values sampled in the cycle the error was taken. Later changes to those inputs have no effect.
- R8: After stacking, the sequencer reads at `VEC_BASE + 8` (the high word) and then at `VEC_BASE + 10` (the low word). `pc_o` becomes the assembled 32-bit value.
- R9: `done_o` is high for exactly one cycle. It rises with the new `pc_o` value already visible.
- R10: While `mem_req_o` is high without `mem_ack_i`, the address, direction and write data stay stable for any number of cycles.
- R11: A bus error during stacking or vector fetch puts the sequencer in a halted state. In that state `halt_o` stays 1, no request is made, and only reset leaves it.
- R12: After reset, `mem_req_o`, `done_o` and `halt_o` are 0 and `pc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_active_i | input | 1 | A bus cycle is in progress |
| berr_i | input | 1 | Bus error line |
| long_frame_i | input | 1 | 1 selects the long frame |
| sr_i | input | 16 | Current status register |
| pc_i | input | 32 | Program counter to stack |
| ssp_i | input | 32 | Supervisor stack pointer |
| fault_addr_i | input | 32 | Faulting access address |
| fault_rw_i | input | 1 | Faulting access was a read |
| fault_instr_i | input | 1 | Faulting access was an instruction fetch |
| fault_fc_i | input | 3 | Function code of the faulting access |
| ir_i | input | 16 | Instruction register |
| state_idx_o | output | IDX_W (5) | Index of the internal state word requested |
| state_word_i | input | 16 | Internal state word at `state_idx_o` |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Transfer accepted this cycle |
| mem_rdata_i | input | 16 | Read data, valid with `mem_ack_i` |
| sr_o | output | 16 | Status register after entry |
| ssp_o | output | 32 | Supervisor stack pointer |
| pc_o | output | 32 | New program counter |
| done_o | output | 1 | One-cycle completion pulse |
| halt_o | output | 1 | Double-fault halt |

## Verification
The bench builds the block with its defaults: 22 long-frame state words, format code 8, vector entry 2 and vector base 0. This makes both the 7-word and the 26-word frame reachable, including the 22-word internal-state run, with the vector reads at byte addresses 8 and 10.

The memory responder inserts random acknowledge delays of 0 to 3 cycles. This exercises back-to-back transfers as well as held requests. Error pulses of random lengths exercise the hold-off before stacking.

A second error raised partway through a frame drives the sequencer into the halted state.

// File: rtl/buserr_pkg.sv
package buserr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PUSH,
    ST_VEC_HI,
    ST_VEC_LO,
    ST_DONE,
    ST_HALT
  } seq_state_e;

  localparam int SR_SUP_BIT   = 13;
  localparam int SR_TRACE_BIT = 15;
  localparam int FRAME_HDR_W  = 3;  // sr, pc hi, pc lo
  localparam int SHORT_ERR_W  = 4;
endpackage

// File: rtl/buserr_capture.sv
module buserr_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              long_i,
  input  logic [15:0]       sr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] fault_addr_i,
  input  logic              fault_rw_i,
  input  logic              fault_instr_i,
  input  logic [2:0]        fault_fc_i,
  input  logic [15:0]       ir_i,
  output logic              long_o,
  output logic [15:0]       sr_frame_o,
  output logic [15:0]       sr_new_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [15:0]       status_o,
  output logic [15:0]       ir_o
);
  import buserr_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      long_o       <= 1'b0;
      sr_frame_o   <= '0;
      pc_o         <= '0;
      fault_addr_o <= '0;
      status_o     <= '0;
      ir_o         <= '0;
    end else if (cap_i) begin
      long_o       <= long_i;
      sr_frame_o   <= sr_i;
      pc_o         <= pc_i;
      fault_addr_o <= fault_addr_i;
      status_o     <= {11'b0, fault_rw_i, fault_instr_i, fault_fc_i};
      ir_o         <= ir_i;
    end
  end

  always_comb begin
    sr_new_o               = sr_frame_o;
    sr_new_o[SR_SUP_BIT]   = 1'b1;
    sr_new_o[SR_TRACE_BIT] = 1'b0;
  end
endmodule

// File: rtl/buserr_frame_mux.sv
module buserr_frame_mux #(
  parameter int          ADDR_W     = 32,
  parameter int          LONG_WORDS = 22,
  parameter logic [3:0]  FMT_CODE   = 4'h8,
  parameter int          VEC_OFF    = 8,
  parameter int          CNT_W      = 5,
  parameter int          IDX_W      = 5
) (
  input  logic              long_i,
  input  logic [CNT_W-1:0]  k_i,
  input  logic [15:0]       sr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] fault_addr_i,
  input  logic [15:0]       status_i,
  input  logic [15:0]       ir_i,
  input  logic [15:0]       state_word_i,
  output logic [IDX_W-1:0]  state_idx_o,
  output logic [15:0]       word_o
);
  import buserr_pkg::*;

  localparam logic [CNT_W-1:0] K_ERR0 = CNT_W'(FRAME_HDR_W);
  localparam logic [15:0]      FMT_WORD = {FMT_CODE, 12'(VEC_OFF)};

  logic [CNT_W-1:0] rel;

  always_comb begin
    rel         = k_i - K_ERR0 - CNT_W'(1);
    state_idx_o = (k_i > K_ERR0) ? IDX_W'(rel) : '0;
  end

  always_comb begin
    word_o = '0;
    if (k_i == CNT_W'(0))       word_o = sr_i;
    else if (k_i == CNT_W'(1))  word_o = pc_i[31:16];
    else if (k_i == CNT_W'(2))  word_o = pc_i[15:0];
    else if (long_i) begin
      word_o = (k_i == K_ERR0) ? FMT_WORD : state_word_i;
    end else begin
      unique case (k_i - K_ERR0)
        CNT_W'(0): word_o = status_i;
        CNT_W'(1): word_o = fault_addr_i[31:16];
        CNT_W'(2): word_o = fault_addr_i[15:0];
        CNT_W'(3): word_o = ir_i;
        default:   word_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/buserr_ctrl.sv
module buserr_ctrl #(
  parameter int          ADDR_W     = 32,
  parameter int          LONG_WORDS = 22,
  parameter logic [31:0] VEC_BASE   = 32'h0,
  parameter int          VEC_OFF    = 8,
  parameter int          CNT_W      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_active_i,
  input  logic              berr_i,
  input  logic              long_i,
  input  logic [ADDR_W-1:0] ssp_i,
  input  logic [15:0]       word_i,
  input  logic              mem_ack_i,
  input  logic [15:0]       mem_rdata_i,
  output logic              cap_o,
  output logic [CNT_W-1:0]  k_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  output logic [ADDR_W-1:0] ssp_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              done_o,
  output logic              halt_o
);
  import buserr_pkg::*;

  localparam int SHORT_N = FRAME_HDR_W + SHORT_ERR_W;
  localparam int LONG_N  = FRAME_HDR_W + 1 + LONG_WORDS;
  localparam logic [ADDR_W-1:0] VEC_HI_A = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_OFF);
  localparam logic [ADDR_W-1:0] VEC_LO_A = VEC_HI_A + ADDR_W'(2);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ADDR_W-1:0] ssp_q;
  logic [15:0]      vec_hi_q;
  logic [ADDR_W-1:0] pc_q;
  logic             in_vec;

  assign cap_o  = (st_q == ST_IDLE) && bus_active_i && berr_i;
  assign in_vec = (st_q == ST_VEC_HI) || (st_q == ST_VEC_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      ssp_q    <= '0;
      vec_hi_q <= '0;
      pc_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cap_o) begin
          st_q  <= ST_WAIT;
          ssp_q <= ssp_i;
        end
        ST_WAIT: if (!bus_active_i && !berr_i) begin
          st_q  <= ST_PUSH;
          cnt_q <= long_i ? CNT_W'(LONG_N - 1) : CNT_W'(SHORT_N - 1);
        end
        ST_PUSH: begin
          if (berr_i) st_q <= ST_HALT;
          else if (mem_ack_i) begin
            ssp_q <= ssp_q - ADDR_W'(2);
            if (cnt_q == '0) st_q <= ST_VEC_HI;
            else             cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_VEC_HI: begin
          if (berr_i) st_q <= ST_HALT;
          else if (mem_ack_i) begin
            vec_hi_q <= mem_rdata_i;
            st_q     <= ST_VEC_LO;
          end
        end
        ST_VEC_LO: begin
          if (berr_i) st_q <= ST_HALT;
          else if (mem_ack_i) begin
            pc_q <= ADDR_W'({vec_hi_q, mem_rdata_i});
            st_q <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        ST_HALT: st_q <= ST_HALT;
        default: st_q <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = (st_q == ST_PUSH) || in_vec;
    mem_we_o    = (st_q == ST_PUSH);
    mem_wdata_o = (st_q == ST_PUSH) ? word_i : '0;
    if (st_q == ST_PUSH)        mem_addr_o = ssp_q - ADDR_W'(2);
    else if (st_q == ST_VEC_LO) mem_addr_o = VEC_LO_A;
    else if (st_q == ST_VEC_HI) mem_addr_o = VEC_HI_A;
    else                        mem_addr_o = '0;
  end

  assign k_o    = cnt_q;
  assign ssp_o  = ssp_q;
  assign pc_o   = pc_q;
  assign done_o = (st_q == ST_DONE);
  assign halt_o = (st_q == ST_HALT);
endmodule

// File: rtl/buserr_seq.sv
module buserr_seq #(
  parameter int          ADDR_W     = 32,
  parameter int          LONG_WORDS = 22,
  parameter logic [3:0]  FMT_CODE   = 4'h8,
  parameter int          VEC_NUM    = 2,
  parameter logic [31:0] VEC_BASE   = 32'h0,
  parameter int          IDX_W      = (LONG_WORDS > 1) ? $clog2(LONG_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_active_i,
  input  logic              berr_i,
  input  logic              long_frame_i,
  input  logic [15:0]       sr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] ssp_i,
  input  logic [ADDR_W-1:0] fault_addr_i,
  input  logic              fault_rw_i,
  input  logic              fault_instr_i,
  input  logic [2:0]        fault_fc_i,
  input  logic [15:0]       ir_i,
  output logic [IDX_W-1:0]  state_idx_o,
  input  logic [15:0]       state_word_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [15:0]       mem_rdata_i,
  output logic [15:0]       sr_o,
  output logic [ADDR_W-1:0] ssp_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              done_o,
  output logic              halt_o
);
  localparam int LONG_N  = 4 + LONG_WORDS;
  localparam int CNT_W   = $clog2(LONG_N + 1);
  localparam int VEC_OFF = VEC_NUM * 4;

  logic              cap;
  logic              long_q;
  logic [15:0]       sr_frame;
  logic [ADDR_W-1:0] pc_cap;
  logic [ADDR_W-1:0] fa_cap;
  logic [15:0]       status_cap;
  logic [15:0]       ir_cap;
  logic [CNT_W-1:0]  k;
  logic [15:0]       word;

  buserr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i, .rst_ni,
    .cap_i        (cap),
    .long_i       (long_frame_i),
    .sr_i, .pc_i, .fault_addr_i, .fault_rw_i, .fault_instr_i, .fault_fc_i, .ir_i,
    .long_o       (long_q),
    .sr_frame_o   (sr_frame),
    .sr_new_o     (sr_o),
    .pc_o         (pc_cap),
    .fault_addr_o (fa_cap),
    .status_o     (status_cap),
    .ir_o         (ir_cap)
  );

  buserr_frame_mux #(
    .ADDR_W(ADDR_W), .LONG_WORDS(LONG_WORDS), .FMT_CODE(FMT_CODE),
    .VEC_OFF(VEC_OFF), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_mux (
    .long_i       (long_q),
    .k_i          (k),
    .sr_i         (sr_frame),
    .pc_i         (pc_cap),
    .fault_addr_i (fa_cap),
    .status_i     (status_cap),
    .ir_i         (ir_cap),
    .state_word_i,
    .state_idx_o,
    .word_o       (word)
  );

  buserr_ctrl #(
    .ADDR_W(ADDR_W), .LONG_WORDS(LONG_WORDS), .VEC_BASE(VEC_BASE),
    .VEC_OFF(VEC_OFF), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .bus_active_i, .berr_i,
    .long_i      (long_q),
    .ssp_i,
    .word_i      (word),
    .mem_ack_i, .mem_rdata_i,
    .cap_o       (cap),
    .k_o         (k),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .ssp_o, .pc_o, .done_o, .halt_o
  );
endmodule

// File: rtl/buserr_seq_chk.sv
module buserr_seq_chk #(
  parameter int          ADDR_W   = 32,
  parameter int          VEC_NUM  = 2,
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_active_i,
  input logic              berr_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [15:0]       mem_wdata_o,
  input logic              mem_ack_i,
  input logic [15:0]       sr_o,
  input logic              done_o,
  input logic              halt_o
);
  localparam logic [ADDR_W-1:0] VA = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_NUM * 4);

  p_hold_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(!berr_i && !bus_active_i));

  p_sup_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (sr_o[13] && !sr_o[15]));

  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i && !berr_i) |=>
      (!(mem_req_o && mem_we_o) || mem_addr_o == $past(mem_addr_o) - ADDR_W'(2)));

  p_vec_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_addr_o == VA || mem_addr_o == VA + ADDR_W'(2)));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !berr_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  p_second_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && berr_i) |=> halt_o);

  p_halt_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && !mem_req_o && !done_o));
endmodule

bind buserr_seq buserr_seq_chk #(
  .ADDR_W(ADDR_W), .VEC_NUM(VEC_NUM), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk_i, .rst_ni, .bus_active_i, .berr_i, .mem_req_o, .mem_we_o,
  .mem_addr_o, .mem_wdata_o, .mem_ack_i, .sr_o, .done_o, .halt_o
);

// File: tb/buserr_seq_tb.sv
`timescale 1ns/1ps
module buserr_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_active_i = 1'b0;
  logic        berr_i = 1'b0;
  logic        long_frame_i = 1'b0;
  logic [15:0] sr_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] ssp_i = '0;
  logic [31:0] fault_addr_i = '0;
  logic        fault_rw_i = 1'b0;
  logic        fault_instr_i = 1'b0;
  logic [2:0]  fault_fc_i = '0;
  logic [15:0] ir_i = '0;
  logic [4:0]  state_idx_o;
  logic [15:0] state_word_i;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_ack_i;
  logic [15:0] mem_rdata_i;
  logic [15:0] sr_o;
  logic [31:0] ssp_o, pc_o;
  logic        done_o, halt_o;

  always #4 clk = ~clk;

  buserr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_active_i, .berr_i, .long_frame_i,
    .sr_i, .pc_i, .ssp_i, .fault_addr_i, .fault_rw_i, .fault_instr_i,
    .fault_fc_i, .ir_i, .state_idx_o, .state_word_i, .mem_req_o, .mem_we_o,
    .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i, .sr_o, .ssp_o,
    .pc_o, .done_o, .halt_o
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // captured case values
  bit          c_long;
  logic [15:0] c_sr, c_ir, c_salt, c_vh, c_vl;
  logic [31:0] c_pc, c_ssp, c_fa;
  logic        c_rw, c_in;
  logic [2:0]  c_fc;
  int          max_wait = 0;

  logic [31:0] wa[64];
  logic [15:0] wd[64];
  logic [31:0] ra[8];
  int nw = 0, nr = 0, stab_bad = 0;

  function automatic logic [15:0] state_fn(int idx);
    return 16'(idx * 257) ^ c_salt;
  endfunction

  assign state_word_i = state_fn(int'(state_idx_o));

  function automatic logic [15:0] vec_word(logic [31:0] a);
    if (a == 32'd8)  return c_vh;
    if (a == 32'd10) return c_vl;
    return 16'hDEAD;
  endfunction

  function automatic logic [15:0] exp_word(int k);
    if (k == 0) return c_sr;
    if (k == 1) return c_pc[31:16];
    if (k == 2) return c_pc[15:0];
    if (c_long) return (k == 3) ? 16'h8008 : state_fn(k - 4);
    case (k)
      3: return {11'b0, c_rw, c_in, c_fc};
      4: return c_fa[31:16];
      5: return c_fa[15:0];
      6: return c_ir;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder with random acknowledge delay
  initial begin : responder
    int d;
    logic [31:0] pa;
    bit pend;
    d = -1;
    pend = 1'b0;
    pa = '0;
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      mem_ack_i = 1'b0;
      if (mem_req_o && !halt_o && rst_n) begin
        if (pend && mem_addr_o != pa) stab_bad++;
        if (d < 0) d = $urandom_range(max_wait, 0);
        if (d == 0) begin
          mem_ack_i = 1'b1;
          if (mem_we_o) begin
            if (nw < 64) begin wa[nw] = mem_addr_o; wd[nw] = mem_wdata_o; end
            nw++;
          end else begin
            mem_rdata_i = vec_word(mem_addr_o);
            if (nr < 8) ra[nr] = mem_addr_o;
            nr++;
          end
          d = -1;
          pend = 1'b0;
        end else begin
          d--;
          pend = 1'b1;
          pa = mem_addr_o;
        end
      end else begin
        d = -1;
        pend = 1'b0;
      end
    end
  end

  task automatic setup_case(bit lng);
    c_long = lng;
    c_sr   = 16'($urandom) | 16'h8000;
    c_pc   = $urandom;
    c_ssp  = 32'h0001_0000 + 32'($urandom_range(1000, 0)) * 2;
    c_fa   = $urandom;
    c_rw   = 1'($urandom);
    c_in   = 1'($urandom);
    c_fc   = 3'($urandom);
    c_ir   = 16'($urandom);
    c_salt = 16'($urandom);
    c_vh   = 16'($urandom);
    c_vl   = 16'($urandom);
    nw = 0; nr = 0; stab_bad = 0;
  endtask

  task automatic scramble();
    sr_i = ~c_sr; pc_i = ~c_pc; fault_addr_i = ~c_fa; ir_i = ~c_ir;
    fault_rw_i = ~c_rw; fault_fc_i = ~c_fc; long_frame_i = ~c_long;
    ssp_i = 32'h0;
  endtask

  task automatic take_error(int hold_a, int hold_b);
    int viol = 0;
    @(negedge clk);
    long_frame_i = c_long; sr_i = c_sr; pc_i = c_pc; ssp_i = c_ssp;
    fault_addr_i = c_fa; fault_rw_i = c_rw; fault_instr_i = c_in;
    fault_fc_i = c_fc; ir_i = c_ir;
    bus_active_i = 1'b1; berr_i = 1'b1;
    @(negedge clk);
    scramble();
    // R2: supervisor set, trace cleared
    chk(sr_o == ((c_sr | 16'h2000) & 16'h7FFF), "R2", 32'(sr_o), 32'((c_sr | 16'h2000) & 16'h7FFF));
    for (int i = 0; i < hold_a; i++) begin
      if (mem_req_o) viol++;
      @(negedge clk);
    end
    bus_active_i = 1'b0;
    for (int i = 0; i < hold_b; i++) begin
      if (mem_req_o) viol++;
      @(negedge clk);
    end
    if (mem_req_o) viol++;
    berr_i = 1'b0;
    chk(viol == 0 && nw == 0, "R1 hold-off", 32'(viol), 32'd0);
  endtask

  task automatic run_case(bit lng, int mw, int hold_a, int hold_b);
    int n;
    int waited;
    logic [31:0] expv;
    max_wait = mw;
    setup_case(lng);
    n = lng ? 26 : 7;
    take_error(hold_a, hold_b);
    waited = 0;
    while (!done_o && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    chk(done_o == 1'b1, "R9 done seen", 32'(done_o), 32'd1);
    chk(nw == n, "R3 word count", 32'(nw), 32'(n));
    for (int j = 0; j < n && j < nw; j++) begin
      chk(wa[j] == c_ssp - 32'(2 * (j + 1)), "R3 address", wa[j], c_ssp - 32'(2 * (j + 1)));
      if (n - 1 - j < 3)
        chk(wd[j] == exp_word(n - 1 - j), "R4 R7 header", 32'(wd[j]), 32'(exp_word(n - 1 - j)));
      else if (lng)
        chk(wd[j] == exp_word(n - 1 - j), "R6 long word", 32'(wd[j]), 32'(exp_word(n - 1 - j)));
      else
        chk(wd[j] == exp_word(n - 1 - j), "R5 short word", 32'(wd[j]), 32'(exp_word(n - 1 - j)));
    end
    chk(ssp_o == c_ssp - 32'(2 * n), "R3 final sp", ssp_o, c_ssp - 32'(2 * n));
    chk(nr == 2 && ra[0] == 32'd8 && ra[1] == 32'd10, "R8 vector reads", ra[0], 32'd8);
    expv = {c_vh, c_vl};
    chk(pc_o == expv, "R8 new pc", pc_o, expv);
    chk(stab_bad == 0, "R10 held request", 32'(stab_bad), 32'd0);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 single pulse", 32'(done_o), 32'd0);
    chk(pc_o == expv, "R9 pc kept", pc_o, expv);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(mem_req_o == 1'b0 && done_o == 1'b0, "R12 req/done", {mem_req_o, done_o}, 32'd0);
    chk(halt_o == 1'b0 && pc_o == 32'd0, "R12 halt/pc", pc_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: error without active bus cycle is ignored
    berr_i = 1'b1;
    repeat (3) @(negedge clk);
    berr_i = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        if (mem_req_o) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R1 ignored error", 32'(seen), 32'd0);
    end

    run_case(1'b0, 0, 0, 0);
    run_case(1'b1, 3, 2, 4);
    for (int t = 0; t < 6; t++)
      run_case(1'($urandom), $urandom_range(3, 0), $urandom_range(4, 0), $urandom_range(4, 0));

    // R11: second error mid-frame
    max_wait = 1;
    setup_case(1'b1);
    take_error(1, 1);
    begin
      int w = 0;
      while (nw < 2 && w < 500) begin @(negedge clk); w++; end
    end
    berr_i = 1'b1;
    @(negedge clk);
    berr_i = 1'b0;
    chk(halt_o == 1'b1, "R11 halt entered", 32'(halt_o), 32'd1);
    begin
      int reqs = 0;
      for (int i = 0; i < 8; i++) begin
        if (mem_req_o) reqs++;
        @(negedge clk);
      end
      chk(reqs == 0, "R11 no requests", 32'(reqs), 32'd0);
    end
    bus_active_i = 1'b1; berr_i = 1'b1;
    @(negedge clk);
    bus_active_i = 1'b0; berr_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(halt_o == 1'b1 && done_o == 1'b0, "R11 sticky", 32'(halt_o), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(halt_o == 1'b0 && mem_req_o == 1'b0, "R12 reset clears halt", 32'(halt_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(1'b0, 2, 1, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule